// File: doc/BRIEF.md
# Quad-I/O Flash Read Responder

This block is a target-side model of the read path of a serial NOR flash. It is meant to sit opposite a host flash controller in a verification environment. A system clock oversamples chip select, the serial clock and four data lanes. The block takes an opcode one bit per clock on lane 0. It then takes a 24-bit address four bits per clock. For the EBh opcode, two clocks of mode bits follow. A fixed run of dummy clocks comes next. After that the block returns bytes from a small internal array, four bits per clock, and the address advances after every byte.

The lanes are split into an input vector, an output vector and a per-lane output enable, so a bench or pad wrapper can build the bidirectional pins. Two opcodes are decoded: EBh (quad read with mode bits) and E7h (quad read without mode bits). Both are accepted only while the quad-enable status input is high.

When the mode bits arrive in their toggled form, the block arms a continuous-read state. The next transaction then skips the opcode and starts directly with the address.

Top module: `qio_read_responder`

## Requirements
- R1: Opcodes EBh and E7h are ignored while `qe_i` is 0. The transaction is then skipped until chip select rises, and no lane is driven.
- R2: The opcode is taken from lane 0 on 8 serial-clock rising edges, most significant bit first. Any opcode other than EBh or E7h is skipped without driving the lanes.
- R3: The address is taken on 6 rising edges, most significant nibble first. On the edge with index j counted from the last, lane k carries address bit 4j+k. Only the low `ADDR_W` bits select a byte.
- R4: EBh has 2 mode clocks and then `DUMMY_CLKS` (default 4) dummy clocks. E7h goes straight to the dummy clocks. The first data nibble is valid on the 21st rising edge for EBh and on the 19th for E7h.
- R5: Each byte is sent on two falling edges, high nibble first. Lane k carries bit 4+k and then bit k, so bit 7 is on lane 3.
- R6: The byte address goes up by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R7: The output enables stay 0 through the opcode, address, mode and dummy clocks. They all go to 1 on the falling edge just before the first data rising edge.
- R8: When chip select goes high, all output enables drop to 0 in the same system-clock cycle. This holds even if a serial-clock fall lands in that cycle. Decoding restarts on the next transaction.
- R9: Mode bits P7..P0 are taken as the lane-3..0 values of the first mode clock (P7..P4) followed by the second (P3..P0). If every pair (P7,P3), (P6,P2), (P5,P1), (P4,P0) differs, the next transaction starts with the address phase as an EBh read. Any other mode value clears this state.
- R10: After reset, the byte at address a holds (a*29 + 5Ah) mod 256, using the defaults `STRIDE`=29 and `SEED`=5Ah.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qe_i | input | 1 | Quad-enable status bit |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| lane_i | input | 4 | Lane values driven by the host |
| lane_o | output | 4 | Lane values driven by the responder |
| lane_oe_o | output | 4 | Per-lane output enable; 0 means high impedance |

## Verification
Two events can fall in the same system-clock cycle: chip select rising, and a serial-clock falling edge that would launch the next nibble. The bench provokes this by ending every transaction with chip select and the serial clock changing on the same edge, once in the middle of a byte. It judges the result by requiring zero output enables one time step after the change, and by requiring that a following read decodes from a clean start. A second overlap is the byte increment meeting the top of the array. A read started three bytes below the top must return the last bytes and then addresses 0 and 1 with no gap.

// File: rtl/qio_pkg.sv
package qio_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_SKIP
  } phase_e;

  localparam logic [7:0] OP_QREAD_MODE = 8'hEB;
  localparam logic [7:0] OP_QREAD_FAST = 8'hE7;
  localparam int CMD_CLKS  = 8;
  localparam int ADDR_CLKS = 6;
  localparam int MODE_CLKS = 2;
  localparam int ADDR_BITS = 24;
endpackage

// File: rtl/qio_pattern_mem.sv
module qio_pattern_mem #(
  parameter int          ADDR_W = 6,
  parameter logic [7:0]  SEED   = 8'h5A,
  parameter logic [7:0]  STRIDE = 8'd29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'(i * int'(STRIDE) + int'(SEED));
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_q[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/qio_phase_ctrl.sv
module qio_phase_ctrl
  import qio_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DUMMY_CLKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_rise_i,
  input  logic [3:0]        lane_i,
  input  logic              qe_i,
  output phase_e            phase_o,
  output logic              addr_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              enh_o
);
  localparam int CNT_W = $clog2(CMD_CLKS + DUMMY_CLKS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_CLKS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] MODE_LAST  = CNT_W'(MODE_CLKS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

  phase_e                 phase_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [ADDR_BITS-1:0]   sr_q;
  logic                   is_eb_q;
  logic                   enh_q;
  logic                   last;
  logic [ADDR_BITS-1:0]   sr_ser_nxt;
  logic [ADDR_BITS-1:0]   sr_quad_nxt;

  assign sr_ser_nxt  = {sr_q[ADDR_BITS-2:0], lane_i[0]};
  assign sr_quad_nxt = {sr_q[ADDR_BITS-5:0], lane_i};

  always_comb begin
    unique case (phase_q)
      PH_CMD:   last = (cnt_q == CMD_LAST);
      PH_ADDR:  last = (cnt_q == ADDR_LAST);
      PH_MODE:  last = (cnt_q == MODE_LAST);
      PH_DUMMY: last = (cnt_q == DUMMY_LAST);
      default:  last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      cnt_q      <= '0;
      sr_q       <= '0;
      is_eb_q    <= 1'b1;
      enh_q      <= 1'b0;
      addr_vld_o <= 1'b0;
      addr_o     <= '0;
    end else begin
      addr_vld_o <= 1'b0;
      if (cs_ni) begin
        phase_q <= enh_q ? PH_ADDR : PH_CMD;
        cnt_q   <= '0;
        sr_q    <= '0;
        is_eb_q <= 1'b1;
      end else if (sclk_rise_i) begin
        if (phase_q inside {PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY})
          cnt_q <= last ? '0 : cnt_q + 1'b1;
        unique case (phase_q)
          PH_CMD: begin
            sr_q <= sr_ser_nxt;
            if (last) begin
              sr_q <= '0;
              if (qe_i && sr_ser_nxt[7:0] == OP_QREAD_MODE) begin
                phase_q <= PH_ADDR;
                is_eb_q <= 1'b1;
              end else if (qe_i && sr_ser_nxt[7:0] == OP_QREAD_FAST) begin
                phase_q <= PH_ADDR;
                is_eb_q <= 1'b0;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
          end
          PH_ADDR: begin
            sr_q <= sr_quad_nxt;
            if (last) begin
              sr_q       <= '0;
              addr_o     <= sr_quad_nxt[ADDR_W-1:0];
              addr_vld_o <= 1'b1;
              phase_q    <= is_eb_q ? PH_MODE : PH_DUMMY;
            end
          end
          PH_MODE: begin
            sr_q <= sr_quad_nxt;
            if (last) begin
              // toggled pairs arm the opcode-less continuation
              enh_q   <= (sr_quad_nxt[7:4] == ~sr_quad_nxt[3:0]);
              phase_q <= PH_DUMMY;
            end
          end
          PH_DUMMY: if (last) phase_q <= PH_DATA;
          default: ;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign enh_o   = enh_q;

  a_r1_qe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && sclk_rise_i && !cs_ni && !qe_i && cnt_q == CMD_LAST)
    |=> phase_q == PH_SKIP);

  a_r2_skip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SKIP && !cs_ni) |=> phase_q == PH_SKIP);

  a_r3_addr_after_addr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> ($past(phase_q) == PH_ADDR && $past(sclk_rise_i)));

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (phase_q == PH_CMD || phase_q == PH_ADDR));

  a_r9_enh_only_from_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(enh_q) |-> $past(phase_q) == PH_MODE);
endmodule

// File: rtl/qio_tx_lane.sv
module qio_tx_lane #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_fall_i,
  input  logic              data_ph_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [3:0]        lane_o,
  output logic [3:0]        lane_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              hi_q;
  logic              drive_q;
  logic [3:0]        lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      hi_q    <= 1'b1;
      drive_q <= 1'b0;
      lane_q  <= '0;
    end else if (cs_ni) begin
      hi_q    <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      if (addr_vld_i) begin
        addr_q <= addr_i;
        hi_q   <= 1'b1;
      end
      if (sclk_fall_i && data_ph_i) begin
        drive_q <= 1'b1;
        lane_q  <= hi_q ? rd_data_i[7:4] : rd_data_i[3:0];
        hi_q    <= ~hi_q;
        if (!hi_q) addr_q <= addr_q + 1'b1;
      end
    end
  end

  // release is combinational so it is not delayed by a clock
  assign lane_oe_o = {4{drive_q & ~cs_ni}};
  assign lane_o    = lane_q;
  assign rd_addr_o = addr_q;

  a_r5_high_nibble_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |-> !hi_q);

  a_r6_increment_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && data_ph_i && !hi_q && !cs_ni && !addr_vld_i)
    |=> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));

  a_r7_drive_only_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> data_ph_i);
endmodule

// File: rtl/qio_read_responder.sv
module qio_read_responder
  import qio_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         DUMMY_CLKS = 4,
  parameter logic [7:0] SEED       = 8'h5A,
  parameter logic [7:0] STRIDE     = 8'd29
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       qe_i,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic [3:0] lane_i,
  output logic [3:0] lane_o,
  output logic [3:0] lane_oe_o
);
  logic              sclk_q;
  logic              sclk_rise;
  logic              sclk_fall;
  phase_e            phase;
  logic              addr_vld;
  logic [ADDR_W-1:0] start_addr;
  logic              enh;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign sclk_rise = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall = ~sclk_i & sclk_q & ~cs_ni;

  qio_phase_ctrl #(.ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sclk_rise_i (sclk_rise),
    .lane_i      (lane_i),
    .qe_i        (qe_i),
    .phase_o     (phase),
    .addr_vld_o  (addr_vld),
    .addr_o      (start_addr),
    .enh_o       (enh)
  );

  qio_pattern_mem #(.ADDR_W(ADDR_W), .SEED(SEED), .STRIDE(STRIDE)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  qio_tx_lane #(.ADDR_W(ADDR_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sclk_fall_i (sclk_fall),
    .data_ph_i   (phase == PH_DATA),
    .addr_vld_i  (addr_vld),
    .addr_i      (start_addr),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .lane_o      (lane_o),
    .lane_oe_o   (lane_oe_o)
  );

  a_r9_enh_needs_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enh && cs_ni) |=> (phase == PH_ADDR));
endmodule

// File: tb/sim_qio_read_responder.sv
module sim_qio_read_responder;
  localparam int HP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qe = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [3:0] lane_i = '0;
  logic [3:0] lane_o;
  logic [3:0] lane_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] nib [32];
  bit pre_oe_any, dat_oe_all, dat_oe_any;
  logic [3:0] rel_oe;

  always #5 clk = ~clk;

  qio_read_responder u0 (
    .clk_i(clk), .rst_ni(rst_n), .qe_i(qe), .cs_ni(cs_n),
    .sclk_i(sclk), .lane_i(lane_i), .lane_o(lane_o), .lane_oe_o(lane_oe)
  );

  function automatic logic [7:0] exp_byte(input int a);
    return 8'((a % 64) * 29 + 8'h5A);
  endfunction

  function automatic logic [7:0] got_byte(input int b);
    return {nib[2*b], nib[2*b+1]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [3:0] tx, output logic [3:0] rx, output logic [3:0] oe);
    sclk = 1'b0;
    lane_i = tx;
    repeat (HP) @(negedge clk);
    rx = lane_o;
    oe = lane_oe;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic xfer(input bit send_cmd, input logic [7:0] op, input logic [23:0] addr,
                      input bit send_mode, input logic [7:0] mode, input int nnib);
    logic [3:0] rx, oe;
    pre_oe_any = 0; dat_oe_all = 1; dat_oe_any = 0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (send_cmd)
      for (int i = 7; i >= 0; i--) begin
        bus_cycle({3'b0, op[i]}, rx, oe);
        pre_oe_any |= |oe;
      end
    for (int j = 5; j >= 0; j--) begin
      bus_cycle(addr[4*j +: 4], rx, oe);
      pre_oe_any |= |oe;
    end
    if (send_mode) begin
      bus_cycle(mode[7:4], rx, oe); pre_oe_any |= |oe;
      bus_cycle(mode[3:0], rx, oe); pre_oe_any |= |oe;
    end
    for (int d = 0; d < 4; d++) begin
      bus_cycle(4'h0, rx, oe);
      pre_oe_any |= |oe;
    end
    for (int n = 0; n < nnib; n++) begin
      bus_cycle(4'h0, rx, oe);
      nib[n] = rx;
      dat_oe_all &= (oe == 4'hF);
      dat_oe_any |= |oe;
    end
    // deselect and serial-clock fall on the same edge
    cs_n = 1'b1;
    sclk = 1'b0;
    #1 rel_oe = lane_oe;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset;
    chk(lane_oe == 4'h0, "R8 reset oe", 32'(lane_oe), 0);
  endtask

  task automatic test_eb_basic;
    xfer(1, 8'hEB, 24'h000005, 1, 8'h00, 8);
    chk(!pre_oe_any, "R7 no drive before data", 32'(pre_oe_any), 0);
    chk(dat_oe_all, "R7 drive in data", 32'(dat_oe_all), 1);
    chk(nib[0] == exp_byte(5)[7:4], "R5 high nibble first", 32'(nib[0]), 32'(exp_byte(5)[7:4]));
    for (int b = 0; b < 4; b++)
      chk(got_byte(b) == exp_byte(5 + b), "R4 R10 EB data", 32'(got_byte(b)), 32'(exp_byte(5 + b)));
    chk(rel_oe == 4'h0, "R8 release on deselect", 32'(rel_oe), 0);
  endtask

  task automatic test_e7_wrap;
    xfer(1, 8'hE7, 24'h00003D, 0, 8'h00, 10);
    chk(!pre_oe_any, "R7 E7 no early drive", 32'(pre_oe_any), 0);
    for (int b = 0; b < 5; b++)
      chk(got_byte(b) == exp_byte(61 + b), "R6 R4 E7 wrap data", 32'(got_byte(b)), 32'(exp_byte(61 + b)));
  endtask

  task automatic test_addr_high_bits;
    xfer(1, 8'hEB, 24'hABCD12, 1, 8'h00, 4);
    chk(got_byte(0) == exp_byte(8'h12), "R3 low address bits", 32'(got_byte(0)), 32'(exp_byte(8'h12)));
    chk(got_byte(1) == exp_byte(8'h13), "R3 next byte", 32'(got_byte(1)), 32'(exp_byte(8'h13)));
  endtask

  task automatic test_qe_off;
    qe = 1'b0;
    xfer(1, 8'hEB, 24'h000004, 1, 8'h00, 4);
    chk(!dat_oe_any, "R1 EB gated by qe", 32'(dat_oe_any), 0);
    xfer(1, 8'hE7, 24'h000004, 0, 8'h00, 4);
    chk(!dat_oe_any, "R1 E7 gated by qe", 32'(dat_oe_any), 0);
    qe = 1'b1;
  endtask

  task automatic test_bad_op;
    xfer(1, 8'h03, 24'h000004, 1, 8'h00, 6);
    chk(!dat_oe_any, "R2 unknown opcode skipped", 32'(dat_oe_any), 0);
    xfer(1, 8'hEA, 24'h000004, 1, 8'h00, 6);
    chk(!dat_oe_any, "R2 near opcode skipped", 32'(dat_oe_any), 0);
  endtask

  task automatic test_enhance;
    xfer(1, 8'hEB, 24'h000010, 1, 8'hA5, 4);
    chk(got_byte(0) == exp_byte(16), "R9 arming read", 32'(got_byte(0)), 32'(exp_byte(16)));
    xfer(0, 8'h00, 24'h000020, 1, 8'hFF, 4);
    chk(dat_oe_all, "R9 opcode skipped drive", 32'(dat_oe_all), 1);
    chk(got_byte(0) == exp_byte(32), "R9 opcode-less read", 32'(got_byte(0)), 32'(exp_byte(32)));
    chk(got_byte(1) == exp_byte(33), "R9 opcode-less next", 32'(got_byte(1)), 32'(exp_byte(33)));
    xfer(1, 8'hEB, 24'h000001, 1, 8'h00, 2);
    chk(got_byte(0) == exp_byte(1), "R9 cleared by plain mode", 32'(got_byte(0)), 32'(exp_byte(1)));
  endtask

  task automatic test_early_cs;
    xfer(1, 8'hEB, 24'h00002A, 1, 8'h00, 1);
    chk(nib[0] == exp_byte(42)[7:4], "R5 first nibble", 32'(nib[0]), 32'(exp_byte(42)[7:4]));
    chk(rel_oe == 4'h0, "R8 mid-byte release", 32'(rel_oe), 0);
    chk(lane_oe == 4'h0, "R8 stays released", 32'(lane_oe), 0);
    xfer(1, 8'hE7, 24'h000007, 0, 8'h00, 2);
    chk(got_byte(0) == exp_byte(7), "R8 restart after abort", 32'(got_byte(0)), 32'(exp_byte(7)));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset;
    test_eb_basic;
    test_e7_wrap;
    test_addr_high_bits;
    test_qe_off;
    test_bad_op;
    test_enhance;
    test_early_cs;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run;
  end
endmodule